// File: doc/BRIEF.md
# EEPROM Page Write Controller

This block models the write side of a byte-wide nonvolatile memory on a synchronous clocked bus. The first accepted byte write opens a load window. Later byte writes are gathered into a 64-slot page buffer. Every accepted write restarts an inactivity timer. When that timer runs out, a programming phase starts. A counter times this phase, and at its end the buffered bytes are copied into the register array.

A load is committed only if every byte in it targets the same page, meaning the same upper address bits. One stray byte cancels the whole load. Only the slots that were actually written reach the array; the other bytes of the page keep their contents. A host can watch two outputs: a busy flag for the programming phase and a load-window status bit. For a period after reset the array refuses writes, and it starts fully erased.

All durations are counted in clock cycles and set by parameters. This lets a system match its real timing, or a bench shorten it. With ADDR_W set to 15 the array covers 32K bytes. The default is smaller so that elaboration stays light.

Top module: `eeprom_page_writer`

## Requirements
- R1: During and right after reset, every array byte reads FFh, busy is 0 and load_closed is 1.
- R2: For PWRUP_CYC cycles after reset is released, writes are ignored: no window opens and the array does not change.
- R3: An accepted write while idle opens the load window, so load_closed is 0 in the next cycle.
- R4: Each accepted write restarts the load timer. After LOAD_CYC consecutive cycles without a write, the window closes and load_closed returns to 1. A write in the cycle the timer would expire keeps the window open.
- R5: Page bits are addr[ADDR_W-1:6] and slot bits are addr[5:0]. If any write in a load has page bits different from the first write, the whole load is dropped: busy never rises and the array is unchanged.
- R6: When a valid load times out, busy is 1 for exactly PROG_CYC cycles, starting with the cycle in which load_closed returns to 1.
- R7: In the cycle busy falls, the array holds the loaded bytes. Only the written slots change, and a slot written twice keeps its last value.
- R8: Writes while busy is 1 are ignored. They neither change the array nor open a window.
- R9: rd_data always shows the array byte at addr, combinationally.
- R10: load_closed is 1 whenever no window is open, both when idle and while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; erases the array |
| wr_en | input | 1 | Byte write strobe for this cycle |
| addr | input | ADDR_W | Byte address for write and read |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Array byte at addr |
| busy | output | 1 | Programming phase in progress |
| load_closed | output | 1 | 0 while the load timer runs, 1 otherwise |

## Verification
Each input pattern below isolates one behaviour:

- A single write during the power-up lockout shows that the lockout is honoured.
- A lone byte write shows the one-byte page case and that neighbouring slots are left untouched.
- A multi-byte load checks the timer boundary:
  - gaps of exactly one cycle less than the timeout must keep the window open;
  - the first and last slots are both written;
  - one slot is written twice, so last-write-wins can be told apart from first-write-wins.
- A load that crosses into another page separates whole-load rejection from partial commit.
- A write issued during programming separates ignoring the write from queuing it.

A behavioural reference model predicts every output on every clock.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W    = 11,
  parameter int OFS_W     = 6,
  parameter int DATA_W    = 8,
  parameter int LOAD_CYC  = 37500,
  parameter int PROG_CYC  = 1250000,
  parameter int PWRUP_CYC = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              load_closed
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SLOTS  = 1 << OFS_W;
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int TMR_W  = $clog2(LOAD_CYC + 1);
  localparam int PRG_W  = $clog2(PROG_CYC + 1);
  localparam int LCK_W  = $clog2(PWRUP_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;

  st_t               st;
  logic [TMR_W-1:0]  tmr;
  logic [PRG_W-1:0]  pcnt;
  logic [LCK_W-1:0]  lck;
  logic [PAGE_W-1:0] page_q;
  logic              stray_q;
  logic [SLOTS-1:0]  mask_q;
  logic [DATA_W-1:0] pbuf [SLOTS];
  logic [DATA_W-1:0] mem  [DEPTH];
  logic              locked;
  logic              take;
  logic              tmo;
  logic              pdone;
  logic [PAGE_W-1:0] in_page;
  logic [OFS_W-1:0]  in_ofs;

  assign in_page     = addr[ADDR_W-1:OFS_W];
  assign in_ofs      = addr[OFS_W-1:0];
  assign locked      = lck != LCK_W'(PWRUP_CYC);
  assign take        = wr_en && !locked && st != S_PROG;
  assign tmo         = tmr == TMR_W'(LOAD_CYC - 1);
  assign pdone       = pcnt == PRG_W'(PROG_CYC - 1);
  assign busy        = st == S_PROG;
  assign load_closed = st != S_LOAD;
  assign rd_data     = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tmr     <= '0;
      pcnt    <= '0;
      lck     <= '0;
      page_q  <= '0;
      stray_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      if (locked) lck <= lck + 1'b1;
      case (st)
        S_IDLE: if (take) begin
          st      <= S_LOAD;
          tmr     <= '0;
          page_q  <= in_page;
          stray_q <= 1'b0;
          mask_q  <= SLOTS'(1) << in_ofs;
        end
        S_LOAD: if (take) begin
          tmr            <= '0;
          mask_q[in_ofs] <= 1'b1;
          if (in_page != page_q) stray_q <= 1'b1;
        end else if (tmo) begin
          st   <= stray_q ? S_IDLE : S_PROG;
          pcnt <= '0;
        end else begin
          tmr <= tmr + 1'b1;
        end
        S_PROG: if (pdone) st <= S_IDLE;
                else       pcnt <= pcnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take) pbuf[in_ofs] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (busy && pdone) begin
      for (int i = 0; i < SLOTS; i++)
        if (mask_q[i]) mem[{page_q, OFS_W'(i)}] <= pbuf[i];
    end
  end
endmodule

module eeprom_page_writer_chk #(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int LOAD_CYC = 37500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy,
  input logic              load_closed,
  input logic              locked
);
  int quiet;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    quiet <= 0;
    else if (load_closed || wr_en) quiet <= 0;
    else                           quiet <= quiet + 1;
  end

  AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (load_closed && !busy)); // R2
  AST_OPEN_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !locked && !busy) |=> !load_closed); // R3
  AST_LOAD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !load_closed |-> quiet < LOAD_CYC); // R4
  AST_BUSY_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!load_closed)); // R6
  AST_ARRAY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy) && $stable(addr)) |-> $stable(rd_data)); // R7
  AST_BUSY_IGNORES_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> load_closed); // R8
  AST_STATUS_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> load_closed); // R10
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOAD_CYC(LOAD_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rd_data(rd_data),
  .busy(busy), .load_closed(load_closed), .locked(locked)
);

// File: tb/eeprom_page_writer_bench.sv
`timescale 1ns/1ps
module eeprom_page_writer_bench;
  localparam int AW = 11, LOAD = 12, PROG = 30, PWRUP = 20;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic busy, load_closed;

  eeprom_page_writer #(.ADDR_W(AW), .LOAD_CYC(LOAD), .PROG_CYC(PROG), .PWRUP_CYC(PWRUP))
    u_eeprom_page_writer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .busy(busy), .load_closed(load_closed));

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  string cur_req = "R1";

  int m_lck, m_st, m_tmr, m_pc, m_page;
  bit m_bad;
  bit [63:0] m_mask;
  byte unsigned m_buf [64];
  byte unsigned m_mem [DEPTH];

  task automatic chk(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lck = 0; m_st = 0; m_tmr = 0; m_pc = 0; m_page = 0; m_bad = 0; m_mask = '0;
      for (int j = 0; j < DEPTH; j++) m_mem[j] = 8'hFF;
    end else begin
      bit acc;
      acc = wr_en && m_lck == PWRUP && m_st != 2;
      if (m_lck < PWRUP) m_lck++;
      case (m_st)
        0: if (acc) begin
          m_st = 1; m_tmr = 0; m_page = int'(addr) / 64; m_bad = 0; m_mask = '0;
          m_mask[int'(addr) % 64] = 1; m_buf[int'(addr) % 64] = wr_data;
        end
        1: if (acc) begin
          m_tmr = 0;
          if (int'(addr) / 64 != m_page) m_bad = 1;
          m_mask[int'(addr) % 64] = 1; m_buf[int'(addr) % 64] = wr_data;
        end else if (m_tmr == LOAD - 1) begin
          m_st = m_bad ? 0 : 2; m_pc = 0;
        end else m_tmr++;
        default: if (m_pc == PROG - 1) begin
          for (int j = 0; j < 64; j++) if (m_mask[j]) m_mem[m_page * 64 + j] = m_buf[j];
          m_st = 0;
        end else m_pc++;
      endcase
    end
    #1;
    if (!finished) begin
      chk("busy", busy, m_st == 2);
      chk("load_closed", load_closed, m_st != 1);
      chk("rd_data", rd_data, m_mem[addr]);
    end
  end

  task automatic wr(int a, int d, int gap);
    wr_en = 1; addr = AW'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic idle(int a, int n);
    addr = AW'(a);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    cur_req = "R1"; idle(0, 3); idle(AW'(DEPTH - 1), 1);
    rst_n = 1; idle(0, 1);
    cur_req = "R2"; wr(12'h0C5, 8'h12, 2); idle(12'h0C5, PWRUP + 2);
    cur_req = "R3"; wr(3 * 64 + 7, 8'h5A, 1);
    cur_req = "R4"; idle(3 * 64 + 7, LOAD - 1);
    cur_req = "R6"; idle(3 * 64 + 7, PROG + 2);
    cur_req = "R7"; idle(3 * 64 + 8, 2);
    cur_req = "R4"; wr(5 * 64 + 0, 8'h11, LOAD - 1); wr(5 * 64 + 63, 8'h22, LOAD - 1);
    cur_req = "R7"; wr(5 * 64 + 10, 8'h33, 1); wr(5 * 64 + 10, 8'h44, LOAD + PROG + 4);
    idle(5 * 64 + 0, 1); idle(5 * 64 + 63, 1); idle(5 * 64 + 10, 1); idle(5 * 64 + 11, 1);
    cur_req = "R5"; wr(8 * 64 + 1, 8'h66, 2); wr(9 * 64 + 2, 8'h77, LOAD + PROG);
    idle(8 * 64 + 1, 1); idle(9 * 64 + 2, 1);
    cur_req = "R8"; wr(2 * 64 + 4, 8'h88, LOAD + 3); wr(2 * 64 + 5, 8'h99, PROG + 4);
    idle(2 * 64 + 4, 1); idle(2 * 64 + 5, 1);
    cur_req = "R10"; idle(0, 4);
    cur_req = "R9";
    for (int a = 0; a < DEPTH; a += 37) idle(a, 1);
    finish_run();
  end
endmodule